// File: doc/BRIEF.md
# Bank Interrupt Line Router

This block sits between the pin slices of one GPIO bank and the interrupt controller. Each pin slice reports a pending bit. The bank has up to eight ports of up to eight pins each. A programmable route mask, held per port and per output line, steers every pending pin onto any subset of up to eight bank interrupt lines. Each output line is the OR of all pending pins routed to it, taken through one register stage.

Software uses a single-cycle register bus. The security window at addresses below 0x1000 holds the route masks and a control register with two sticky lock bits. One lock freezes the routing. The other hides the route masks from reads. The port window at 0x1000 and above exposes, for each port and each line, which pins of that port are both pending and routed to that line. Pin detection and the clearing of pending state stay in the pin slices.

Top module: `bank_irq_router`

## Requirements
- R1: After reset, the route mask of every port for line 0 has one bit set for each implemented pin of that port, and all other masks are zero. Both lock bits, every interrupt line and the read data are zero.
- R2: The route mask for port p and line x is at security-window address 0x14 + p*0x20 + x*4. Bit n routes pin n of port p. Write data bits 7:0 are stored, and bits for pins the port does not implement are stored as zero. A read returns the mask in bits 7:0 on the bus one cycle after the request.
- R3: Interrupt line x is high in the cycle after any port has a pending pin whose bit is set in that port's mask for line x. Otherwise it is low.
- R4: The status for port p and line x is at address 0x1000 + p*0x200 + 0x100 + x*4. It returns, in bits 7:0, the pins of port p that are pending and routed to line x. Bits for unimplemented pins read as zero.
- R5: The control register is at address 0x00C. Writing 1 to bit 28 sets the write lock, and writing 1 to bit 27 sets the read lock. A read returns both bits in those positions and zero elsewhere.
- R6: A lock bit that has been set stays set until reset, whatever is written afterwards.
- R7: While the write lock is set, writes to route masks are ignored, and the routing of interrupts does not change.
- R8: While the read lock is set, route-mask reads return zero. Control and status reads are not affected.
- R9: Pin n of port p is pending input bit p*8 + n.
- R10: A read of any address that decodes to no register returns zero. A write to such an address changes no mask and no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bit 12 selects the port window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pend_in | input | 64 | Pending bits, pin n of port p at p*8+n |
| irq_out | output | 8 | Bank interrupt lines, registered |

## Verification
The assertions assume that the pending inputs are synchronous to the clock, and that the bus never issues a write and a read in the same cycle. They also assume that the instance configuration gives every port between one and eight pins. The bench holds a request for exactly one clock and changes pending bits only on the falling edge. Because of this, every registered result is taken from stable inputs, and each read sees the masks as left by the previous write. Pending bits on unimplemented pins are driven on purpose, since the design has to discard them.

// File: rtl/bank_irq_router_pkg.sv
package bank_irq_router_pkg;

  localparam int unsigned MAX_PINS   = 8;
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned ADDR_W     = 13;
  localparam int unsigned DATA_W     = 32;

  localparam logic [11:0] CTL_OFS        = 12'h00C;
  localparam logic [11:0] ROUTE_BASE     = 12'h014;
  localparam int unsigned WLOCK_POS      = 28;
  localparam int unsigned RLOCK_POS      = 27;

  typedef logic [MAX_PINS-1:0] pin_vec_t;

  // Mask with one bit per implemented pin; counts of eight or more fill the byte.
  function automatic pin_vec_t fill_mask(input logic [3:0] cnt);
    if (cnt >= 4'd8) return 8'hFF;
    return pin_vec_t'((9'h1 << cnt) - 9'h1);
  endfunction

  // Word shown by the control register for the two lock bits.
  function automatic logic [DATA_W-1:0] ctl_word(input logic wl, input logic rl);
    logic [DATA_W-1:0] w;
    w = '0;
    w[WLOCK_POS] = wl;
    w[RLOCK_POS] = rl;
    return w;
  endfunction

endpackage

// File: rtl/bank_irq_router_decode.sv
module bank_irq_router_decode
  import bank_irq_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctl,
  output logic              hit_route,
  output logic              hit_status,
  output logic [IDX_W-1:0]  sel_port,
  output logic [IDX_W-1:0]  sel_line
);

  localparam logic [3:0] NP = 4'(NUM_PORTS);
  localparam logic [3:0] NL = 4'(NUM_LINES);

  logic [11:0]      ofs;
  logic [11:0]      rel;
  logic             port_win;
  logic [IDX_W-1:0] r_port, r_line, s_port, s_line;

  assign ofs      = addr[11:0];
  assign port_win = addr[12];
  assign rel      = ofs - ROUTE_BASE;
  assign r_port   = rel[7:5];
  assign r_line   = rel[4:2];
  assign s_port   = addr[11:9];
  assign s_line   = addr[4:2];

  assign hit_ctl   = !port_win && (ofs == CTL_OFS);

  assign hit_route = !port_win && (ofs >= ROUTE_BASE) && (rel[11:8] == 4'd0)
                   && (rel[1:0] == 2'd0)
                   && ({1'b0, r_port} < NP) && ({1'b0, r_line} < NL);

  assign hit_status = port_win && addr[8] && (addr[7:5] == 3'd0)
                    && (addr[1:0] == 2'd0)
                    && ({1'b0, s_port} < NP) && ({1'b0, s_line} < NL);

  assign sel_port = port_win ? s_port : r_port;
  assign sel_line = port_win ? s_line : r_line;

  always_comb begin
    assert (!(hit_ctl && hit_route) && !(hit_route && hit_status)
            && !(hit_ctl && hit_status)); // R10
  end

endmodule

// File: rtl/bank_irq_router_regs.sv
module bank_irq_router_regs
  import bank_irq_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_route,
  input  logic                                   wr_ctl,
  input  logic [IDX_W-1:0]                       sel_port,
  input  logic [IDX_W-1:0]                       sel_line,
  input  pin_vec_t                               wmask,
  input  logic                                   set_wlock,
  input  logic                                   set_rlock,
  input  logic [NUM_PORTS-1:0][MAX_PINS-1:0]     impl_mask,
  output logic [NUM_PORTS-1:0][NUM_LINES-1:0][MAX_PINS-1:0] route_q,
  output logic                                   wlock_q,
  output logic                                   rlock_q,
  output logic                                   route_commit
);

  // A route write only lands while the routing is not frozen.
  assign route_commit = wr_route && !wlock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlock_q <= 1'b0;
      rlock_q <= 1'b0;
    end else if (wr_ctl) begin
      wlock_q <= wlock_q | set_wlock;
      rlock_q <= rlock_q | set_rlock;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
      logic sel_here;
      assign sel_here = route_commit && (sel_port == IDX_W'(p))
                      && (sel_line == IDX_W'(x));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          route_q[p][x] <= (x == 0) ? impl_mask[p] : '0;
        end else if (sel_here) begin
          route_q[p][x] <= wmask & impl_mask[p];
        end
      end
    end
  end

  AST_WLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wlock_q |=> wlock_q); // R6
  AST_RLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rlock_q |=> rlock_q); // R6
  AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    wlock_q |=> $stable(route_q)); // R7

endmodule

// File: rtl/bank_irq_router_merge.sv
module bank_irq_router_merge
  import bank_irq_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_PORTS*MAX_PINS-1:0]          pend,
  input  logic [NUM_PORTS-1:0][NUM_LINES-1:0][MAX_PINS-1:0] route_q,
  input  logic [NUM_PORTS-1:0][MAX_PINS-1:0]     impl_mask,
  output logic [NUM_PORTS-1:0][NUM_LINES-1:0][MAX_PINS-1:0] routed,
  output logic [NUM_LINES-1:0]                   line_hit,
  output logic [NUM_LINES-1:0]                   irq_q
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
      assign routed[p][x] = pend[p*MAX_PINS +: MAX_PINS] & route_q[p][x] & impl_mask[p];
    end
  end

  always_comb begin
    line_hit = '0;
    for (int x = 0; x < NUM_LINES; x++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        line_hit[x] = line_hit[x] | (|routed[p][x]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_hit;
  end

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (irq_q == '0)); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> (irq_q == '0)); // R3

endmodule

// File: rtl/bank_irq_router.sv
module bank_irq_router
  import bank_irq_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned NUM_LINES = 8,
  parameter logic [4*NUM_PORTS-1:0] PORT_PINS = 32'h8348_5678
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*MAX_PINS-1:0] pend_in,
  output logic [NUM_LINES-1:0]          irq_out
);

  logic [NUM_PORTS-1:0][MAX_PINS-1:0]                   impl_mask;
  logic [NUM_PORTS-1:0][NUM_LINES-1:0][MAX_PINS-1:0]    route_q;
  logic [NUM_PORTS-1:0][NUM_LINES-1:0][MAX_PINS-1:0]    routed;
  logic [NUM_LINES-1:0] line_hit;
  logic                 hit_ctl, hit_route, hit_status;
  logic [IDX_W-1:0]     sel_port, sel_line;
  logic                 wlock_q, rlock_q, route_commit;
  logic                 rd_req, wr_req;
  logic [DATA_W-1:0]    rd_value;
  logic [DATA_W-1:0]    rdata_q;
  logic                 unused_wdata_bits;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_impl
    assign impl_mask[p] = fill_mask(PORT_PINS[p*4 +: 4]);
  end

  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid &&  bus_write;
  assign unused_wdata_bits = ^{bus_wdata[31:29], bus_wdata[26:8]};

  bank_irq_router_decode #(.NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES)) u_decode (
    .addr       (bus_addr),
    .hit_ctl    (hit_ctl),
    .hit_route  (hit_route),
    .hit_status (hit_status),
    .sel_port   (sel_port),
    .sel_line   (sel_line)
  );

  bank_irq_router_regs #(.NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_route     (wr_req && hit_route),
    .wr_ctl       (wr_req && hit_ctl),
    .sel_port     (sel_port),
    .sel_line     (sel_line),
    .wmask        (bus_wdata[MAX_PINS-1:0]),
    .set_wlock    (bus_wdata[WLOCK_POS]),
    .set_rlock    (bus_wdata[RLOCK_POS]),
    .impl_mask    (impl_mask),
    .route_q      (route_q),
    .wlock_q      (wlock_q),
    .rlock_q      (rlock_q),
    .route_commit (route_commit)
  );

  bank_irq_router_merge #(.NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_in),
    .route_q   (route_q),
    .impl_mask (impl_mask),
    .routed    (routed),
    .line_hit  (line_hit),
    .irq_q     (irq_out)
  );

  always_comb begin
    rd_value = '0;
    if (hit_ctl) begin
      rd_value = ctl_word(wlock_q, rlock_q);
    end else if (hit_route) begin
      if (!rlock_q) rd_value[MAX_PINS-1:0] = route_q[sel_port][sel_line];
    end else if (hit_status) begin
      rd_value[MAX_PINS-1:0] = routed[sel_port][sel_line];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_value;
  end

  assign bus_rdata = rdata_q;

  AST_RLOCK_HIDES_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hit_route && rlock_q) |=> (bus_rdata == '0)); // R8
  AST_STATUS_NO_GHOST_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hit_status) |=>
      ((bus_rdata[MAX_PINS-1:0] & ~$past(impl_mask[sel_port])) == '0)); // R4
  AST_NARROW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (hit_route || hit_status)) |=> (bus_rdata[DATA_W-1:MAX_PINS] == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !hit_ctl && !hit_route && !hit_status) |=> (bus_rdata == '0)); // R10
  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && hit_route && wlock_q) |-> !route_commit); // R7

endmodule

// File: tb/bank_irq_router_tb.sv
module bank_irq_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NL = 8;
  localparam int PINS [NP] = '{8, 7, 6, 5, 8, 4, 3, 8};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pend_in = '0;
  logic [7:0]  irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [NP][NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_irq_router #(.NUM_PORTS(8), .NUM_LINES(8), .PORT_PINS(32'h8348_5678)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_in(pend_in), .irq_out(irq_out)
  );

  function automatic logic [7:0] pins_of(int p);
    return 8'((1 << PINS[p]) - 1);
  endfunction

  function automatic logic [12:0] route_addr(int p, int x);
    return 13'(20 + 32 * p + 4 * x);
  endfunction

  function automatic logic [12:0] status_addr(int p, int x);
    return 13'(4096 + 512 * p + 256 + 4 * x);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd_check(logic [12:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pend_irq_check(logic [63:0] pv, string req);
    logic [7:0] exp;
    exp = '0;
    for (int x = 0; x < NL; x++)
      for (int p = 0; p < NP; p++)
        if ((pv[p*8 +: 8] & model[p][x]) != 0) exp[x] = 1'b1;
    @(negedge clk);
    pend_in = pv;
    @(negedge clk);
    check(req, {24'b0, irq_out}, {24'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++)
        model[p][x] = (x == 0) ? pins_of(p) : 8'h00;

    #(CLK_PERIOD * 3 + 2);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {24'b0, irq_out}, 32'h0);
    rst_n = 1'b1;

    // R1: reset masks, lock state
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++)
        bus_rd_check(route_addr(p, x), {24'b0, model[p][x]}, "R1 mask default");
    bus_rd_check(13'h00C, 32'h0, "R1 locks clear");

    // R1/R3: default routing sends every implemented pin to line 0 only
    pend_irq_check(64'hFFFF_FFFF_FFFF_FFFF, "R1 default line0");

    // R2: write patterns with junk high bits, stored trimmed to the pin count
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++) begin
        logic [7:0] pat;
        pat = 8'((p * 37 + x * 11 + 5) ^ (x * 64));
        bus_wr(route_addr(p, x), 32'hABCD_0000 | 32'(pat) | 32'hF00);
        model[p][x] = pat & pins_of(p);
      end
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++)
        bus_rd_check(route_addr(p, x), {24'b0, model[p][x]}, "R2 mask readback");

    // R3/R9: every single pin, including unimplemented ones
    for (int b = 0; b < 64; b++)
      pend_irq_check(64'h1 << b, "R3 R9 single pin");
    pend_irq_check(64'h0, "R3 no pending");
    pend_irq_check(64'hFFFF_FFFF_FFFF_FFFF, "R3 all pending");

    // R4: status per port and line under two pending patterns
    for (int k = 0; k < 2; k++) begin
      logic [63:0] pv;
      for (int p = 0; p < NP; p++)
        pv[p*8 +: 8] = (k == 0) ? 8'(8'h5A ^ (p * 19)) : 8'hFF;
      @(negedge clk);
      pend_in = pv;
      for (int p = 0; p < NP; p++)
        for (int x = 0; x < NL; x++)
          bus_rd_check(status_addr(p, x), {24'b0, pv[p*8 +: 8] & model[p][x]}, "R4 status");
    end

    // R10: unmapped reads and writes
    bus_wr(13'h0004, 32'hFFFF_FFFF);
    bus_wr(13'h1000, 32'hFFFF_FFFF);
    bus_rd_check(13'h0004, 32'h0, "R10 unmapped read");
    bus_rd_check(13'h1104 + 13'h0002, 32'h0, "R10 misaligned read");
    bus_rd_check(13'h0114, 32'h0, "R10 past last mask");
    bus_rd_check(13'h00C, 32'h0, "R10 no lock from unmapped write");
    bus_rd_check(route_addr(3, 4), {24'b0, model[3][4]}, "R10 mask untouched");

    // R5/R7: write lock
    bus_wr(13'h00C, 32'h1000_0000);
    bus_rd_check(13'h00C, 32'h1000_0000, "R5 write lock readback");
    bus_wr(route_addr(2, 3), 32'h0000_0000);
    bus_wr(route_addr(0, 0), 32'h0000_00FF ^ {24'b0, model[0][0]});
    bus_rd_check(route_addr(2, 3), {24'b0, model[2][3]}, "R7 locked write ignored");
    bus_rd_check(route_addr(0, 0), {24'b0, model[0][0]}, "R7 locked write ignored");
    pend_irq_check(64'hFFFF_FFFF_FFFF_FFFF, "R7 routing unchanged");

    // R5/R8: read lock
    bus_wr(13'h00C, 32'h0800_0000);
    bus_rd_check(13'h00C, 32'h1800_0000, "R5 both locks");
    bus_rd_check(route_addr(2, 3), 32'h0, "R8 locked read zero");
    bus_rd_check(route_addr(7, 7), 32'h0, "R8 locked read zero");
    bus_rd_check(status_addr(0, 0), {24'b0, model[0][0]}, "R8 status still visible");

    // R6: locks survive a write of zero
    bus_wr(13'h00C, 32'h0);
    bus_rd_check(13'h00C, 32'h1800_0000, "R6 locks sticky");

    pend_in = '0;
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule